// File: doc/BRIEF.md
# Single-Shot Comparator Control Unit

This block turns raw address-comparator match strobes into per-slot resource events for a trace unit. It holds a build-time number of control slots. Each slot has a selection mask over the single-address comparator strobes and the address-range comparator strobes. A slot matches in a cycle when any strobe it selects is high.

Each slot also has a mode bit. In single-shot mode a slot fires once and then stays quiet until its sticky status bit is cleared. In multi-shot mode it fires on every matching cycle. Software programs the slots through a small indexed write/read port. Writes are accepted only while the trace unit reports idle. Accesses to slots that were not built are flagged as undefined.

Mask bits for comparators that the build does not implement are forced to zero on write, so those bits can never cause a match. Control words have no defined value after reset, so every slot must be programmed before use. Status bits and output pulses do reset.

Top module: `oneshot_match_ctl`

## Requirements
- R1: While `unit_idle` is high, a write to a present slot replaces its control word. A later read returns it one cycle after `reg_rd`. The layout is: bits 15:0 single-address select, bits 23:16 range select, bit 24 mode (0 single-shot, 1 multi-shot). Bits 31:25 always read as zero.
- R2: Range select bit m is stored as zero when m >= N_PAIRS. Single-address select bit m is stored as zero when m >= 2*N_PAIRS. A strobe on a line whose select bit was forced to zero never fires the slot.
- R3: A write to a present slot while `unit_idle` is low leaves the control word unchanged. `wr_reject` pulses high for exactly the cycle after the write.
- R4: A write or read whose `reg_idx` is >= N_SLOTS pulses `acc_undef` for the following cycle. Such a read returns zero, and such a write changes no slot.
- R5: A slot matches when any selected single-address strobe or any selected range strobe is high. The resulting `fired` pulse appears in the cycle after the match.
- R6: In single-shot mode, the first match raises `fired` for one cycle and sets the sticky `status` bit. Later matches produce no pulse while `status` stays set.
- R7: A high `sts_clr` bit clears that slot's status, so a later match fires again. If a clear and a match occur in the same cycle, the slot fires and `status` remains set.
- R8: In multi-shot mode, every matching cycle produces a `fired` pulse in the next cycle and sets `status`.
- R9: A slot whose selection masks are all zero never fires and never sets `status`.
- R10: After reset, `fired`, `status`, `acc_undef`, `wr_reject` and `reg_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sa_hit | input | 16 | Single-address comparator match strobes |
| rng_hit | input | 8 | Address-range comparator match strobes |
| unit_idle | input | 1 | Trace unit is idle; writes allowed |
| reg_wr | input | 1 | Control word write strobe |
| reg_rd | input | 1 | Control word read strobe |
| reg_idx | input | 3 | Slot index for the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| acc_undef | output | 1 | Access targeted an absent slot (one-cycle pulse) |
| wr_reject | output | 1 | Write refused because the unit was busy (one-cycle pulse) |
| sts_clr | input | N_SLOTS | Per-slot status clear |
| fired | output | N_SLOTS | Per-slot event pulses |
| status | output | N_SLOTS | Per-slot sticky status bits |

## Verification
A wrong sticky status bit shows at the ports within one cycle. A stuck-set bit suppresses the next single-shot pulse. A bit that fails to set lets a second pulse through right after the first. A corrupted stored mask appears at once on readback, and on the cycle after the next strobe as a pulse on the wrong slot or a missing pulse. Lost writes or wrongly accepted busy-time writes appear on the read that follows, together with the flag pulse one cycle after the access.

// File: rtl/osm_pkg.sv
package osm_pkg;

    localparam int SA_LINES   = 16;
    localparam int RNG_LINES  = 8;
    localparam int IDX_W      = 3;
    localparam int BUS_W      = 32;
    localparam int WORD_W     = 1 + RNG_LINES + SA_LINES;

    typedef struct packed {
        logic                 multi;
        logic [RNG_LINES-1:0] rng;
        logic [SA_LINES-1:0]  sa;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_OK,
        ACC_UNDEF,
        ACC_REJECT
    } acc_kind_t;

    // Bits a control word may hold for a given number of comparator pairs.
    function automatic slot_cfg_t legal_bits(input int unsigned pairs);
        slot_cfg_t m;
        m = '0;
        m.multi = 1'b1;
        for (int i = 0; i < RNG_LINES; i++)
            if (i < int'(pairs)) m.rng[i] = 1'b1;
        for (int i = 0; i < SA_LINES; i++)
            if (i < 2 * int'(pairs)) m.sa[i] = 1'b1;
        return m;
    endfunction

    function automatic slot_cfg_t clip_word(input logic [BUS_W-1:0] raw,
                                            input slot_cfg_t legal);
        slot_cfg_t w;
        w = slot_cfg_t'(raw[WORD_W-1:0]);
        return slot_cfg_t'(w & legal);
    endfunction

endpackage

// File: rtl/osm_access.sv
module osm_access
    import osm_pkg::*;
#(
    parameter int N_SLOTS = 6
) (
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic               unit_idle,
    output acc_kind_t          kind,
    output logic [N_SLOTS-1:0] wr_en,
    output logic               rd_ok
);

    logic present;

    always_comb begin
        present = (int'(reg_idx) < N_SLOTS);
        kind    = ACC_NONE;
        wr_en   = '0;
        rd_ok   = reg_rd && present;
        if (reg_wr || reg_rd) begin
            if (!present)
                kind = ACC_UNDEF;
            else if (reg_wr && !unit_idle)
                kind = ACC_REJECT;
            else
                kind = ACC_OK;
        end
        for (int s = 0; s < N_SLOTS; s++)
            if (reg_wr && unit_idle && reg_idx == IDX_W'(s))
                wr_en[s] = 1'b1;
    end

endmodule

// File: rtl/osm_cfg_bank.sv
module osm_cfg_bank
    import osm_pkg::*;
#(
    parameter int N_SLOTS = 6,
    parameter int N_PAIRS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SLOTS-1:0]       wr_en,
    input  logic [BUS_W-1:0]         wdata,
    input  logic                     rd_any,
    input  logic                     rd_ok,
    input  logic [IDX_W-1:0]         rd_idx,
    output slot_cfg_t [N_SLOTS-1:0]  cfg_q,
    output logic [BUS_W-1:0]         rdata
);

    localparam slot_cfg_t LEGAL = legal_bits(N_PAIRS);
    localparam int        PAD_W = BUS_W - WORD_W;

    // Control words carry no reset: their post-reset value is undefined.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en[s])
                cfg_q[s] <= clip_word(wdata, LEGAL);
        end
    end

    slot_cfg_t rd_word;

    always_comb begin
        rd_word = '0;
        for (int s = 0; s < N_SLOTS; s++)
            if (rd_ok && rd_idx == IDX_W'(s))
                rd_word = cfg_q[s];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_any)
            rdata <= {{PAD_W{1'b0}}, rd_word};
    end

endmodule

// File: rtl/osm_slot.sv
module osm_slot
    import osm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  slot_cfg_t            cfg,
    input  logic [SA_LINES-1:0]  sa_hit,
    input  logic [RNG_LINES-1:0] rng_hit,
    input  logic                 clr,
    output logic                 fired,
    output logic                 status
);

    logic match;
    logic armed;

    always_comb begin
        match = (|(cfg.sa & sa_hit)) || (|(cfg.rng & rng_hit));
        armed = cfg.multi || !status || clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fired  <= 1'b0;
            status <= 1'b0;
        end else begin
            fired  <= match && armed;
            status <= match || (status && !clr);
        end
    end

endmodule

// File: rtl/oneshot_match_ctl.sv
module oneshot_match_ctl
    import osm_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int N_SLOTS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          sa_hit,
    input  logic [7:0]           rng_hit,
    input  logic                 unit_idle,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [2:0]           reg_idx,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 acc_undef,
    output logic                 wr_reject,
    input  logic [N_SLOTS-1:0]   sts_clr,
    output logic [N_SLOTS-1:0]   fired,
    output logic [N_SLOTS-1:0]   status
);

    acc_kind_t               kind;
    logic [N_SLOTS-1:0]      wr_en;
    logic                    rd_ok;
    slot_cfg_t [N_SLOTS-1:0] cfg_q;
    logic [N_SLOTS-1:0]      mode_multi;
    logic [N_SLOTS-1:0]      sel_any;

    osm_access #(.N_SLOTS(N_SLOTS)) u_access (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_idx   (reg_idx),
        .unit_idle (unit_idle),
        .kind      (kind),
        .wr_en     (wr_en),
        .rd_ok     (rd_ok)
    );

    osm_cfg_bank #(.N_SLOTS(N_SLOTS), .N_PAIRS(N_PAIRS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wdata  (reg_wdata),
        .rd_any (reg_rd),
        .rd_ok  (rd_ok),
        .rd_idx (reg_idx),
        .cfg_q  (cfg_q),
        .rdata  (reg_rdata)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        osm_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg_q[s]),
            .sa_hit  (sa_hit),
            .rng_hit (rng_hit),
            .clr     (sts_clr[s]),
            .fired   (fired[s]),
            .status  (status[s])
        );
        assign mode_multi[s] = cfg_q[s].multi;
        assign sel_any[s]    = |{cfg_q[s].rng, cfg_q[s].sa};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_undef <= 1'b0;
            wr_reject <= 1'b0;
        end else begin
            acc_undef <= (kind == ACC_UNDEF);
            wr_reject <= (kind == ACC_REJECT);
        end
    end

endmodule

// File: rtl/osm_chk.sv
module osm_chk #(
    parameter int N_SLOTS = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [N_SLOTS-1:0] fired,
    input logic [N_SLOTS-1:0] status,
    input logic [N_SLOTS-1:0] sts_clr,
    input logic [N_SLOTS-1:0] mode_multi,
    input logic [N_SLOTS-1:0] sel_any,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic               unit_idle,
    input logic               acc_undef,
    input logic               wr_reject
);

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_chk
        // R6
        fired_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
            fired[s] |-> status[s]);

        // R6
        single_no_refire_chk: assert property (@(posedge clk) disable iff (rst)
            (fired[s] && !mode_multi[s] && !sts_clr[s]) |=> !fired[s]);

        // R9
        empty_sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            fired[s] |-> $past(sel_any[s]));
    end

    // R3
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> $past(reg_wr && !unit_idle));

    // R4
    undef_origin_chk: assert property (@(posedge clk) disable iff (rst)
        acc_undef |-> $past(reg_wr || reg_rd));

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_undef && wr_reject));

endmodule

bind oneshot_match_ctl osm_chk #(.N_SLOTS(N_SLOTS)) u_osm_chk (
    .clk        (clk),
    .rst        (rst),
    .fired      (fired),
    .status     (status),
    .sts_clr    (sts_clr),
    .mode_multi (mode_multi),
    .sel_any    (sel_any),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .unit_idle  (unit_idle),
    .acc_undef  (acc_undef),
    .wr_reject  (wr_reject)
);

// File: tb/oneshot_match_ctl_bench.sv
`timescale 1ns/1ps
module oneshot_match_ctl_bench;

    localparam int NP = 4;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [15:0]   sa_hit;
    logic [7:0]    rng_hit;
    logic          unit_idle;
    logic          reg_wr;
    logic          reg_rd;
    logic [2:0]    reg_idx;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          acc_undef;
    logic          wr_reject;
    logic [NS-1:0] sts_clr;
    logic [NS-1:0] fired;
    logic [NS-1:0] status;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    oneshot_match_ctl #(.N_PAIRS(NP), .N_SLOTS(NS)) u_oneshot_match_ctl (
        .clk(clk), .rst(rst), .sa_hit(sa_hit), .rng_hit(rng_hit),
        .unit_idle(unit_idle), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_undef(acc_undef), .wr_reject(wr_reject), .sts_clr(sts_clr),
        .fired(fired), .status(status)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        reg_rd = 1'b1; reg_idx = idx;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] sa, input logic [7:0] rg,
                         input logic [NS-1:0] clr);
        sa_hit = sa; rng_hit = rg; sts_clr = clr;
        tick();
        sa_hit = '0; rng_hit = '0; sts_clr = '0;
    endtask

    task automatic t_reset();
        chk("R10 fired", 32'(fired), 32'h0);
        chk("R10 status", 32'(status), 32'h0);
        chk("R10 flags", {30'h0, acc_undef, wr_reject}, 32'h0);
        chk("R10 rdata", reg_rdata, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        unit_idle = 1'b1;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d);
        chk("R1/R2 all-ones readback", d, 32'h010F_00FF);
        wr(3'd3, 32'h00A5_1234);
        rd(3'd3, d);
        chk("R2 masked readback", d, 32'h0005_0034);
    endtask

    task automatic t_reject();
        logic [31:0] d;
        unit_idle = 1'b0;
        wr(3'd3, 32'hFFFF_FFFF);
        chk("R3 reject flag", {31'h0, wr_reject}, 32'h1);
        chk("R3 no undef", {31'h0, acc_undef}, 32'h0);
        tick();
        chk("R3 flag one cycle", {31'h0, wr_reject}, 32'h0);
        rd(3'd3, d);
        chk("R3 word kept", d, 32'h0005_0034);
        unit_idle = 1'b1;
    endtask

    task automatic t_undef();
        logic [31:0] d;
        wr(3'd6, 32'h0000_00FF);
        chk("R4 undef on write", {31'h0, acc_undef}, 32'h1);
        rd(3'd7, d);
        chk("R4 undef on read", {31'h0, acc_undef}, 32'h1);
        chk("R4 absent read zero", d, 32'h0);
        rd(3'd0, d);
        chk("R4 present read no flag", {31'h0, acc_undef}, 32'h0);
        chk("R4 absent write changed nothing", d, 32'h010F_00FF);
    endtask

    task automatic t_setup();
        wr(3'd0, 32'h0100_0001);
        wr(3'd1, 32'h0000_0004);
        wr(3'd2, 32'h0002_0000);
        wr(3'd3, 32'h0000_0000);
        wr(3'd4, 32'h0101_0020);
        wr(3'd5, 32'h0000_1008);
        pulse('0, '0, '1);
        chk("R7 clear all", 32'(status), 32'h0);
    endtask

    task automatic t_single();
        pulse(16'h0004, '0, '0);
        chk("R6 first pulse", 32'(fired), 32'h02);
        chk("R6 status set", 32'(status[1]), 32'h1);
        tick();
        chk("R6 pulse one cycle", 32'(fired), 32'h0);
        pulse(16'h0004, '0, '0);
        chk("R6 no refire", 32'(fired), 32'h0);
        chk("R6 status sticky", 32'(status[1]), 32'h1);
    endtask

    task automatic t_range();
        pulse('0, 8'h02, '0);
        chk("R5 range match", 32'(fired), 32'h04);
        pulse(16'h1000, '0, '0);
        chk("R2 masked sa line quiet", 32'(fired), 32'h0);
        chk("R2 masked sa no status", 32'(status[5]), 32'h0);
        pulse('0, 8'h20, '0);
        chk("R2 masked rng line quiet", 32'(fired), 32'h0);
    endtask

    task automatic t_clear();
        pulse('0, '0, 6'b000010);
        chk("R7 status cleared", 32'(status[1]), 32'h0);
        pulse(16'h0004, '0, '0);
        chk("R7 fires after clear", 32'(fired), 32'h02);
        pulse(16'h0004, '0, 6'b000010);
        chk("R7 clear+match fires", 32'(fired), 32'h02);
        chk("R7 clear+match status", 32'(status[1]), 32'h1);
        pulse(16'h0004, '0, '0);
        chk("R7 rearmed once only", 32'(fired), 32'h0);
    endtask

    task automatic t_multi();
        sa_hit = 16'h0001;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8 repeated pulse", 32'(fired), 32'h01);
        end
        sa_hit = '0;
        tick();
        chk("R8 stops with strobe", 32'(fired), 32'h0);
        chk("R8 status set", 32'(status[0]), 32'h1);
        pulse('0, 8'h01, '0);
        chk("R5 OR range side", 32'(fired), 32'h10);
        pulse(16'h0020, '0, '0);
        chk("R5 OR address side", 32'(fired), 32'h10);
    endtask

    task automatic t_zero();
        pulse(16'hFFFF, 8'hFF, '0);
        chk("R9 empty slot silent", 32'(fired[3]), 32'h0);
        pulse(16'hFFFF, 8'hFF, '0);
        chk("R9 empty slot status", 32'(status[3]), 32'h0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        rst = 1'b1; sa_hit = '0; rng_hit = '0; unit_idle = 1'b1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_idx = '0; reg_wdata = '0;
        sts_clr = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_regs();
        t_reject();
        t_undef();
        t_setup();
        t_single();
        t_range();
        t_clear();
        t_multi();
        t_zero();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule